// File: doc/BRIEF.md
# SPI Status and Error Flag Controller

This block keeps the status flags and interrupt requests of a double-buffered SPI peripheral. It sits between a simple CPU register bus and an SPI shift engine. The bus side gives one-cycle strobes for a status read, a control write (with data), a data read and a data write. The engine side reports:

- a completed received byte;
- the transmit buffer being loaded into the shift register;
- whether a transfer is in progress;
- the level of the slave-select pin;
- whether the peripheral is master or slave.

The block tracks transmit-empty, receive-full, overflow and mode-fault. Overflow and mode-fault each clear only through a two-access sequence. The sequence opens with a status read that sees the flag set. A later second access then completes it: a data read for overflow, a control write for mode-fault. Each error flag has its own "armed" bit that remembers the opening read. A fresh error event drops the armed bit, so an error that arrives mid-sequence is not lost. Two combinational outputs tell the neighbouring data path when a written byte is accepted into the transmit buffer and when a received byte may be latched into the receive buffer.

The control register holds three bits:

| Bit | Function |
|-----|----------|
| 0 | Error-interrupt enable |
| 1 | Transmit-interrupt enable |
| 2 | Mode-fault detection enable |

The asynchronous reset is released synchronously through a short synchronizer.

Top module: `spi_flag_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, transmit-empty reads 1. Receive-full, overflow, mode-fault, all three control bits and both interrupt requests read 0.
- R2: A byte-complete strobe raises `rx_capture` in the same cycle and sets receive-full on the next clock edge, when receive-full is 0 or a data read occurs in that cycle. A data read clears receive-full.
- R3: A byte-complete strobe while receive-full is 1 and no data read occurs sets overflow on the next edge. It holds `rx_capture` low, so the stored byte is kept and the new one is dropped.
- R4: Overflow clears only on a data read that follows a status read which saw overflow at 1. A data read with no such prior status read leaves overflow set.
- R5: In slave mode with detection enabled, a low-to-high change of slave-select while the transfer-active input is 1 sets mode-fault. The same change while no transfer is active does not.
- R6: In master mode with detection enabled, slave-select low sets mode-fault. With detection disabled it does not.
- R7: Mode-fault clears only on a control write that follows a status read which saw mode-fault at 1. A control write with no such prior status read leaves mode-fault set.
- R8: A data write while transmit-empty is 1 raises `tx_accept` and clears transmit-empty on the next edge. A load strobe from the engine sets transmit-empty on the next edge.
- R9: A data write while transmit-empty is 0 is ignored. `tx_accept` stays 0 and transmit-empty stays 0.
- R10: `irq_err` is 1 exactly when control bit 0 is 1 and overflow or mode-fault is set. `irq_tx` is 1 exactly when control bit 1 is 1 and transmit-empty is set. A control write takes effect on the next edge.
- R11: If an error flag's set event occurs after the opening status read and before the second access, that second access does not clear the flag.
- R12: When a flag's set event and its clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | Status register read strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data: bit0 error-interrupt enable, bit1 transmit-interrupt enable, bit2 mode-fault detection enable |
| data_rd | input | 1 | Receive data register read strobe |
| data_wr | input | 1 | Transmit data register write strobe |
| eng_byte_done | input | 1 | Shift engine finished receiving a byte |
| eng_load_ack | input | 1 | Shift engine took the transmit buffer byte |
| eng_busy | input | 1 | Transfer in progress |
| ss_level | input | 1 | Slave-select pin level |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer full flag |
| ovf_flag | output | 1 | Overflow flag |
| mf_flag | output | 1 | Mode-fault flag |
| irq_err | output | 1 | Error interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| tx_accept | output | 1 | Data write accepted into transmit buffer (combinational) |
| rx_capture | output | 1 | Received byte may be latched into receive buffer (combinational) |

## Verification
Every flag and both interrupt requests respond on the first clock edge after the strobe or event. `tx_accept` and `rx_capture` respond within the cycle of their inputs. The bench drives inputs at the falling edge and compares the registered results at the next falling edge, one full edge after the update. It samples the two combinational outputs one nanosecond after driving, before the rising edge. The reset checks are taken both while reset is held, since the clear is asynchronous, and after the three cycles the release synchronizer needs.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

  // Control register layout; bit positions are visible to software.
  typedef struct packed {
    logic flt_en;   // bit 2: mode-fault detection enable
    logic tx_ie;    // bit 1: transmit interrupt enable
    logic err_ie;   // bit 0: error interrupt enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/spi_err_flag.sv
// Sticky error flag with a two-access clearing sequence.
module spi_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,   // error condition this cycle
  input  logic obs_rd,    // status read (opens sequence if flag is 1)
  input  logic fin_acc,   // second access (completes sequence if armed)
  output logic flag,
  output logic armed
);

  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr_ok;

  assign clr_ok = fin_acc & arm_q;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (set_evt) begin
      // New event wins over clearing and drops any open sequence.
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (clr_ok) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (obs_rd && flag_q) begin
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag  = flag_q;
  assign armed = arm_q;

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              eng_byte_done,
  input  logic              eng_load_ack,
  input  logic              eng_busy,
  input  logic              ss_level,
  input  logic              is_master,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              ovf_flag,
  output logic              mf_flag,
  output logic              irq_err,
  output logic              irq_tx,
  output logic              tx_accept,
  output logic              rx_capture
);

  logic  rst_sync_n;
  ctrl_t ctrl_q, ctrl_d;
  logic  txe_q, txe_d;
  logic  rxf_q, rxf_d;
  logic  ss_q;
  logic  flt_en;
  logic  ovf_evt, mf_evt;
  logic  slave_fault, master_fault;
  logic  ovf_armed, mf_armed;

  spi_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Control register
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = ctrl_t'(ctrl_wdata);
    end
  end

  assign flt_en = ctrl_q.flt_en;

  // Buffer handshakes
  assign tx_accept  = data_wr & txe_q;
  assign rx_capture = eng_byte_done & (~rxf_q | data_rd);
  assign ovf_evt    = eng_byte_done & rxf_q & ~data_rd;

  always_comb begin
    txe_d = txe_q;
    if (eng_load_ack) begin
      txe_d = 1'b1;
    end else if (tx_accept) begin
      txe_d = 1'b0;
    end
  end

  always_comb begin
    rxf_d = rxf_q;
    if (rx_capture) begin
      rxf_d = 1'b1;
    end else if (data_rd) begin
      rxf_d = 1'b0;
    end
  end

  // Mode-fault detection
  assign slave_fault  = ~is_master & eng_busy & ss_level & ~ss_q;
  assign master_fault = is_master & ~ss_level;
  assign mf_evt       = flt_en & (slave_fault | master_fault);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      txe_q  <= 1'b1;
      rxf_q  <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      ctrl_q <= ctrl_d;
      txe_q  <= txe_d;
      rxf_q  <= rxf_d;
      ss_q   <= ss_level;
    end
  end

  spi_err_flag i_ovf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (ovf_evt),
    .obs_rd  (stat_rd),
    .fin_acc (data_rd),
    .flag    (ovf_flag),
    .armed   (ovf_armed)
  );

  spi_err_flag i_mf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (mf_evt),
    .obs_rd  (stat_rd),
    .fin_acc (ctrl_wr),
    .flag    (mf_flag),
    .armed   (mf_armed)
  );

  assign tx_empty = txe_q;
  assign rx_full  = rxf_q;
  assign irq_err  = ctrl_q.err_ie & (ovf_flag | mf_flag);
  assign irq_tx   = ctrl_q.tx_ie & txe_q;

endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_wr,
  input logic data_rd,
  input logic data_wr,
  input logic byte_done,
  input logic load_ack,
  input logic is_master,
  input logic ss_level,
  input logic fault_en,
  input logic tx_empty,
  input logic rx_full,
  input logic ovf_flag,
  input logic mf_flag,
  input logic tx_accept,
  input logic rx_capture
);

  a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !rx_full |=> rx_full);

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_full && !data_rd |=> ovf_flag);

  a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_full && !data_rd |-> !rx_capture);

  a_r4_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !data_rd |=> ovf_flag);

  a_r6_master_fault: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && fault_en && !ss_level |=> mf_flag);

  a_r7_mf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mf_flag && !ctrl_wr |=> mf_flag);

  a_r8_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> tx_empty);

  a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept && !load_ack |=> !tx_empty);

  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !tx_empty |-> !tx_accept);

endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ctrl_wr    (ctrl_wr),
  .data_rd    (data_rd),
  .data_wr    (data_wr),
  .byte_done  (eng_byte_done),
  .load_ack   (eng_load_ack),
  .is_master  (is_master),
  .ss_level   (ss_level),
  .fault_en   (flt_en),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .ovf_flag   (ovf_flag),
  .mf_flag    (mf_flag),
  .tx_accept  (tx_accept),
  .rx_capture (rx_capture)
);

// File: tb/test_spi_flag_ctrl.sv
`timescale 1ns/1ps
module test_spi_flag_ctrl;

  logic clk;
  logic rst_n;
  logic stat_rd, ctrl_wr, data_rd, data_wr;
  logic [2:0] ctrl_wdata;
  logic eng_byte_done, eng_load_ack, eng_busy, ss_level, is_master;
  logic tx_empty, rx_full, ovf_flag, mf_flag, irq_err, irq_tx, tx_accept, rx_capture;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  spi_flag_ctrl i_spi_flag_ctrl (
    .clk (clk), .rst_n (rst_n),
    .stat_rd (stat_rd), .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata),
    .data_rd (data_rd), .data_wr (data_wr),
    .eng_byte_done (eng_byte_done), .eng_load_ack (eng_load_ack),
    .eng_busy (eng_busy), .ss_level (ss_level), .is_master (is_master),
    .tx_empty (tx_empty), .rx_full (rx_full), .ovf_flag (ovf_flag),
    .mf_flag (mf_flag), .irq_err (irq_err), .irq_tx (irq_tx),
    .tx_accept (tx_accept), .rx_capture (rx_capture)
  );

  // Vector: req[21:18] sr cw cd[15:13] dr dw bd la bsy ss ms | expected
  // {tx_empty rx_full ovf mf irq_err irq_tx}[5:0], due at the next falling edge.
  localparam int NV = 38;
  localparam logic [21:0] VEC [NV] = '{
    22'b0001_0_0_000_0_0_0_0_0_1_0_100000, // R1 idle
    22'b1010_0_1_011_0_0_0_0_0_1_0_100001, // R10 enable err+tx irq
    22'b1000_0_0_000_0_1_0_0_0_1_0_000000, // R8 write accepted
    22'b1001_0_0_000_0_1_0_0_0_1_0_000000, // R9 write ignored
    22'b1000_0_0_000_0_0_0_1_0_1_0_100001, // R8 load ack
    22'b0010_0_0_000_0_0_1_0_0_1_0_110001, // R2 byte arrives
    22'b0011_0_0_000_0_0_1_0_0_1_0_111011, // R3 overflow
    22'b0100_0_0_000_1_0_0_0_0_1_0_101011, // R4 data read w/o status read
    22'b0100_1_0_000_0_0_0_0_0_1_0_101011, // R4 status read arms
    22'b0100_0_0_000_1_0_0_0_0_1_0_100001, // R4 data read clears
    22'b0010_0_0_000_0_0_1_0_0_1_0_110001, // R2
    22'b0011_0_0_000_0_0_1_0_0_1_0_111011, // R3
    22'b1011_1_0_000_0_0_0_0_0_1_0_111011, // R11 arm
    22'b1011_0_0_000_0_0_1_0_0_1_0_111011, // R11 new overflow disarms
    22'b1011_0_0_000_1_0_0_0_0_1_0_101011, // R11 read leaves overflow
    22'b0100_1_0_000_0_0_0_0_0_1_0_101011, // R4 arm
    22'b0010_0_0_000_0_0_1_0_0_1_0_111011, // R2 byte into empty buffer
    22'b0010_0_0_000_1_0_1_0_0_1_0_110001, // R2 byte with read, ovf clears
    22'b0010_0_0_000_1_0_0_0_0_1_0_100001, // R2 read empties
    22'b1010_0_1_101_0_0_0_0_0_1_0_100000, // R10 err irq + fault detect
    22'b0101_0_0_000_0_0_0_0_1_0_0_100000, // R5 ss low, busy
    22'b0101_0_0_000_0_0_0_0_1_1_0_100110, // R5 ss rises while busy
    22'b0111_0_1_101_0_0_0_0_0_1_0_100110, // R7 ctrl write w/o status read
    22'b0111_1_0_000_0_0_0_0_0_1_0_100110, // R7 arm
    22'b0111_0_1_101_0_0_0_0_0_1_0_100000, // R7 ctrl write clears
    22'b0101_0_0_000_0_0_0_0_0_0_0_100000, // R5 ss low idle
    22'b0101_0_0_000_0_0_0_0_0_1_0_100000, // R5 rise while idle: no fault
    22'b0110_0_0_000_0_0_0_0_0_0_1_100110, // R6 master, ss low
    22'b0110_1_0_000_0_0_0_0_0_1_1_100110, // R6 arm
    22'b0111_0_1_101_0_0_0_0_0_1_1_100000, // R7 clear
    22'b0110_0_0_000_0_0_0_0_0_0_1_100110, // R6
    22'b1011_1_0_000_0_0_0_0_0_1_1_100110, // R11 arm
    22'b1100_0_1_101_0_0_0_0_0_0_1_100110, // R12 set and clear together
    22'b1011_0_1_101_0_0_0_0_0_1_1_100110, // R11 disarmed, stays set
    22'b0111_1_0_000_0_0_0_0_0_1_0_100110, // R7 arm
    22'b1010_0_1_001_0_0_0_0_0_1_0_100000, // R10 clear mf, detect off
    22'b0110_0_0_000_0_0_0_0_0_0_1_100000, // R6 detect off: no fault
    22'b1100_0_0_000_0_1_0_1_0_1_0_100000  // R12 write+load: stays empty
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [5:0] outs();
    return {tx_empty, rx_full, ovf_flag, mf_flag, irq_err, irq_tx};
  endfunction

  task automatic idle_inputs;
    stat_rd = 0; ctrl_wr = 0; ctrl_wdata = 0; data_rd = 0; data_wr = 0;
    eng_byte_done = 0; eng_load_ack = 0; eng_busy = 0; ss_level = 1; is_master = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    check("R1 in reset", outs(), 6'b100000);
    rst_n = 1;
    repeat (3) tick();
    check("R1 after release", outs(), 6'b100000);

    for (int i = 0; i < NV; i++) begin
      stat_rd       = VEC[i][17];
      ctrl_wr       = VEC[i][16];
      ctrl_wdata    = VEC[i][15:13];
      data_rd       = VEC[i][12];
      data_wr       = VEC[i][11];
      eng_byte_done = VEC[i][10];
      eng_load_ack  = VEC[i][9];
      eng_busy      = VEC[i][8];
      ss_level      = VEC[i][7];
      is_master     = VEC[i][6];
      tick();
      check($sformatf("R%0d vector %0d", VEC[i][21:18], i), outs(), VEC[i][5:0]);
    end
    idle_inputs();

    // R8 / R9: combinational accept, ignored write keeps buffer full
    data_wr = 1;
    #1 check("R8 tx_accept", {5'b0, tx_accept}, 6'd1);
    tick();
    #1 check("R9 tx_accept low", {5'b0, tx_accept}, 6'd0);
    tick();
    check("R9 tx_empty stays 0", {5'b0, tx_empty}, 6'd0);
    data_wr = 0;

    // R2 / R3: receive latch enable
    eng_byte_done = 1;
    #1 check("R2 rx_capture empty", {5'b0, rx_capture}, 6'd1);
    tick();
    #1 check("R3 rx_capture dropped", {5'b0, rx_capture}, 6'd0);
    tick();
    data_rd = 1;
    #1 check("R2 rx_capture with read", {5'b0, rx_capture}, 6'd1);
    tick();
    eng_byte_done = 0; data_rd = 0;

    // R10 then R1: asynchronous reset clears flags and enables
    ctrl_wr = 1; ctrl_wdata = 3'b011;
    tick();
    ctrl_wr = 0; ctrl_wdata = 0;
    check("R10 irq_err with ovf", {5'b0, irq_err}, 6'd1);
    rst_n = 0;
    #1 check("R1 async clear", outs(), 6'b100000);
    tick();
    rst_n = 1;
    repeat (3) tick();
    check("R1 enables cleared", outs(), 6'b100000);

    finish_run();
  end

endmodule